// File: doc/BRIEF.md
# Block Memory Transfer Engine

This engine copies a run of bytes from one region of a byte-wide, single-port memory to another. A one-cycle start pulse captures a 16-bit source address, a 16-bit destination address, a 16-bit byte count and a 3-bit mode. Each byte then takes two cycles. In the fetch cycle the engine drives the source address with the read strobe. In the store cycle it drives the destination address with the write strobe and forwards the returned read data as write data. The memory is expected to present read data in the cycle after the read strobe.

The mode sets a stepping rule for each pointer, applied after every byte. The rules are increment, decrement, hold, or swing between the start address and the next address up. The controller is a four-state machine: `ST_IDLE`, `ST_READ`, `ST_WRITE` and `ST_DONE`. Its transitions are:

- **accept**: `ST_IDLE` to `ST_READ` on start.
- **fetch**: `ST_READ` to `ST_WRITE`, always.
- **next**: `ST_WRITE` to `ST_READ` when bytes remain.
- **finish**: `ST_WRITE` to `ST_DONE` after the last byte.
- **retire**: `ST_DONE` to `ST_IDLE`, always.

Top module: `blk_xfer_engine`

## Requirements
- R1: Mode code 0 steps both the source and the destination up by one after each byte.
- R2: Mode code 1 steps both the source and the destination down by one after each byte.
- R3: Mode code 2 steps the source up by one after each byte and keeps the destination at its start address.
- R4: Mode code 3 steps the source up by one. The destination swings between its start address D and D+1, giving D, D+1, D, D+1 and so on.
- R5: Mode code 4 swings the source between its start address S and S+1, giving S, S+1, S and so on. The destination steps up by one after each byte.
- R6: Mode codes 5, 6 and 7 behave exactly like mode code 0.
- R7: Each byte is a read cycle followed by a write cycle.
  - The read cycle has `mem_rd`=1 and `mem_addr` set to the source pointer.
  - The next cycle has `mem_wr`=1, `mem_addr` set to the destination pointer, and `mem_wdata` equal to `mem_rdata` in that cycle.
  - `mem_rd` and `mem_wr` are never high together.
- R8: A count of N from 1 to 65535 moves exactly N bytes. A count of 0 moves 65536 bytes.
- R9: Pointer steps wrap modulo 65536: FFFF+1 gives 0000, and 0000-1 gives FFFF.
- R10: `busy` is high for exactly 2N cycles, starting in the cycle after the accepted start. `done` is high for exactly one cycle, the cycle after the final write, and `busy` is low in that cycle.
- R11: A start pulse while the engine is busy or signalling done is ignored. The running transfer keeps its operands, and the engine stays quiet once that transfer ends.
- R12: During and after reset the engine is idle, with `busy`, `done`, `mem_rd` and `mem_wr` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| src_i | input | 16 | Source start address |
| dst_i | input | 16 | Destination start address |
| len_i | input | 16 | Byte count; 0 means 65536 |
| mode_i | input | 3 | Stepping mode code (0 to 4; 5 to 7 act as 0) |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bound checker holds the following on every cycle:
- The read and write strobes never overlap, and every read is followed at once by a write.
- The strobes appear only while busy, and `done` is a single cycle that follows a write with `busy` low.
- An accepted start raises `busy`, and a start while busy leaves it high.
- The destination rules for mode codes 0, 1 and 2 hold from one write to the next.

Only the bench scenarios can show the rest:
- the exact source and destination sequences, including the swinging patterns and the wrap at the ends of the address space;
- the byte count, including the 65536-byte case;
- the reserved mode codes;
- that data fetched from the right address lands at the right address.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    typedef enum logic [2:0] {
        MODE_UP_UP    = 3'd0,
        MODE_DN_DN    = 3'd1,
        MODE_UP_HOLD  = 3'd2,
        MODE_UP_SWING = 3'd3,
        MODE_SWING_UP = 3'd4
    } xfer_mode_t;

    typedef enum logic [1:0] {
        STEP_UP    = 2'd0,
        STEP_DOWN  = 2'd1,
        STEP_HOLD  = 2'd2,
        STEP_SWING = 2'd3
    } step_rule_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } xfer_state_t;

    function automatic step_rule_t src_rule(input logic [2:0] code);
        step_rule_t r;
        unique case (code)
            MODE_DN_DN:    r = STEP_DOWN;
            MODE_SWING_UP: r = STEP_SWING;
            default:       r = STEP_UP;
        endcase
        return r;
    endfunction

    function automatic step_rule_t dst_rule(input logic [2:0] code);
        step_rule_t r;
        unique case (code)
            MODE_DN_DN:    r = STEP_DOWN;
            MODE_UP_HOLD:  r = STEP_HOLD;
            MODE_UP_SWING: r = STEP_SWING;
            default:       r = STEP_UP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/blk_xfer_stepper.sv
module blk_xfer_stepper
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  step_rule_t    rule_i,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    step_rule_t rule_q;
    logic       phase_q;

    // Pointer, its stepping rule, and the swing phase (0 = at base).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            rule_q  <= STEP_UP;
            phase_q <= 1'b0;
        end else if (load) begin
            addr    <= base;
            rule_q  <= rule_i;
            phase_q <= 1'b0;
        end else if (adv) begin
            unique case (rule_q)
                STEP_UP:    addr <= addr + ONE;
                STEP_DOWN:  addr <= addr - ONE;
                STEP_HOLD:  addr <= addr;
                STEP_SWING: begin
                    addr    <= phase_q ? addr - ONE : addr + ONE;
                    phase_q <= ~phase_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/blk_xfer_count.sv
module blk_xfer_count #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] len,
    input  logic          dec,
    output logic          last
);

    localparam logic [LW-1:0] ONE = LW'(1);

    logic [LW-1:0] left_q;

    // A loaded zero wraps through all ones, giving 2**LW bytes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= ONE;
        end else if (load) begin
            left_q <= len;
        end else if (dec) begin
            left_q <= left_q - ONE;
        end
    end

    assign last = (left_q == ONE);

endmodule

// File: rtl/blk_xfer_ctrl.sv
module blk_xfer_ctrl
    import blk_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last,
    output logic load,
    output logic src_adv,
    output logic dst_adv,
    output logic cnt_dec,
    output logic rd,
    output logic wr,
    output logic busy,
    output logic done
);

    xfer_state_t state_q;
    xfer_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;                 // accept
            ST_READ:  state_d = ST_WRITE;                           // fetch
            ST_WRITE: state_d = last ? ST_DONE : ST_READ;           // finish / next
            ST_DONE:  state_d = ST_IDLE;                            // retire
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load    = 1'b0;
        src_adv = 1'b0;
        dst_adv = 1'b0;
        cnt_dec = 1'b0;
        rd      = 1'b0;
        wr      = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_READ: begin
                rd      = 1'b1;
                src_adv = 1'b1;
                busy    = 1'b1;
            end
            ST_WRITE: begin
                wr      = 1'b1;
                dst_adv = 1'b1;
                cnt_dec = 1'b1;
                busy    = 1'b1;
            end
            ST_DONE:  done = 1'b1;
        endcase
    end

endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [LW-1:0] len_i,
    input  logic [2:0]    mode_i,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done
);

    logic          load;
    logic          src_adv;
    logic          dst_adv;
    logic          cnt_dec;
    logic          last;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;

    blk_xfer_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .last    (last),
        .load    (load),
        .src_adv (src_adv),
        .dst_adv (dst_adv),
        .cnt_dec (cnt_dec),
        .rd      (mem_rd),
        .wr      (mem_wr),
        .busy    (busy),
        .done    (done)
    );

    blk_xfer_stepper #(.AW(AW)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .base   (src_i),
        .rule_i (src_rule(mode_i)),
        .adv    (src_adv),
        .addr   (src_addr)
    );

    blk_xfer_stepper #(.AW(AW)) u_dst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .base   (dst_i),
        .rule_i (dst_rule(mode_i)),
        .adv    (dst_adv),
        .addr   (dst_addr)
    );

    blk_xfer_count #(.LW(LW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .len   (len_i),
        .dec   (cnt_dec),
        .last  (last)
    );

    assign mem_addr  = mem_wr ? dst_addr : src_addr;
    assign mem_wdata = mem_rdata;

endmodule

// File: rtl/blk_xfer_engine_chk.sv
module blk_xfer_engine_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    mode_i,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          busy,
    input logic          done
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [2:0]    cap_mode;
    logic          seen_wr;
    logic [AW-1:0] prev_wr;

    // Shadow of the mode and last write address, from the ports only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mode <= 3'd0;
            seen_wr  <= 1'b0;
            prev_wr  <= '0;
        end else if (start && !busy && !done) begin
            cap_mode <= mode_i;
            seen_wr  <= 1'b0;
        end else if (mem_wr) begin
            seen_wr  <= 1'b1;
            prev_wr  <= mem_addr;
        end
    end

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_follows_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    p_strobe_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(mem_wr)));

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && mem_rd) |=> busy);

    p_dst_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && seen_wr && cap_mode == 3'd0) |-> mem_addr == prev_wr + ONE);

    p_dst_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && seen_wr && cap_mode == 3'd1) |-> mem_addr == prev_wr - ONE);

    p_dst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && seen_wr && cap_mode == 3'd2) |-> mem_addr == prev_wr);

endmodule

bind blk_xfer_engine blk_xfer_engine_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_i   (mode_i),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .busy     (busy),
    .done     (done)
);

// File: tb/blk_xfer_engine_test.sv
module blk_xfer_engine_test;

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] len;
        logic [15:0] last;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 16'h1000, 16'h2000, 16'd5, 16'h2004},  // R1
        '{3'd1, 16'h1010, 16'h2010, 16'd4, 16'h200D},  // R2
        '{3'd2, 16'h3000, 16'h0400, 16'd6, 16'h0400},  // R3
        '{3'd3, 16'h3100, 16'h0500, 16'd5, 16'h0500},  // R4
        '{3'd4, 16'h3200, 16'h0600, 16'd4, 16'h0603},  // R5
        '{3'd0, 16'h4000, 16'h4100, 16'd1, 16'h4100},  // R8 single byte
        '{3'd0, 16'hFFFE, 16'hFFFF, 16'd3, 16'h0001},  // R9 upward wrap
        '{3'd1, 16'h0001, 16'h0000, 16'd3, 16'hFFFE},  // R9 downward wrap
        '{3'd3, 16'h0010, 16'hFFFF, 16'd4, 16'h0000},  // R4 R9 swing wrap
        '{3'd6, 16'h5000, 16'h6000, 16'd2, 16'h6001}   // R6 reserved code
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [15:0] len_i = '0;
    logic [2:0]  mode_i = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    blk_xfer_engine uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .src_i     (src_i),
        .dst_i     (dst_i),
        .len_i     (len_i),
        .mode_i    (mode_i),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Rules: 0 up, 1 down, 2 hold, 3 swing.
    function automatic logic [1:0] s_rule(input logic [2:0] m);
        if (m == 3'd1) return 2'd1;
        if (m == 3'd4) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [1:0] d_rule(input logic [2:0] m);
        if (m == 3'd1) return 2'd1;
        if (m == 3'd2) return 2'd2;
        if (m == 3'd3) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [15:0] nxt(input logic [1:0] r, input logic [15:0] a,
                                        input logic ph);
        case (r)
            2'd0:    return a + 16'd1;
            2'd1:    return a - 16'd1;
            2'd2:    return a;
            default: return ph ? a - 16'd1 : a + 16'd1;
        endcase
    endfunction

    // Read model: data appears the cycle after the read strobe.
    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    // Monitor state
    logic        mon_on = 1'b0;
    logic [1:0]  m_sr, m_dr;
    logic [15:0] e_src, e_dst, e_data, last_wr;
    logic        s_ph, d_ph;
    int          nwr, nbusy, seq_err;
    logic [15:0] err_act, err_exp;

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) nbusy++;
            if (mem_rd) begin
                if (mem_addr !== e_src && seq_err == 0) begin
                    err_act = mem_addr; err_exp = e_src;
                end
                if (mem_addr !== e_src) seq_err++;
                e_data = {8'h00, pat(e_src)};
                e_src  = nxt(m_sr, e_src, s_ph);
                if (m_sr == 2'd3) s_ph = ~s_ph;
            end
            if (mem_wr) begin
                if ((mem_addr !== e_dst || mem_wdata !== e_data[7:0]) && seq_err == 0) begin
                    err_act = (mem_addr !== e_dst) ? mem_addr : {8'h00, mem_wdata};
                    err_exp = (mem_addr !== e_dst) ? e_dst : e_data;
                end
                if (mem_addr !== e_dst || mem_wdata !== e_data[7:0]) seq_err++;
                last_wr = mem_addr;
                nwr++;
                e_dst = nxt(m_dr, e_dst, d_ph);
                if (m_dr == 2'd3) d_ph = ~d_ph;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] m, input logic [15:0] s, input logic [15:0] d,
                       input logic [15:0] n, input logic [15:0] exp_last,
                       input string req, input bit poke);
        int nbytes;
        nbytes = (n == 16'd0) ? 65536 : int'(n);
        m_sr = s_rule(m); m_dr = d_rule(m);
        e_src = s; e_dst = d; s_ph = 1'b0; d_ph = 1'b0;
        nwr = 0; nbusy = 0; seq_err = 0; err_act = '0; err_exp = '0;
        mon_on = 1'b1;
        @(negedge clk);
        start = 1'b1; src_i = s; dst_i = d; len_i = n; mode_i = m;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; src_i = 16'h0000; dst_i = 16'h0000;
            len_i = 16'd9; mode_i = 3'd1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        check({req, " address/data sequence"}, {16'h0, err_act}, {16'h0, err_exp});
        check({req, " sequence mismatches"}, seq_err, 0);
        check("R8 byte count", nwr, nbytes);
        check({req, " last write address"}, {16'h0, last_wr}, {16'h0, exp_last});
        check("R10 busy cycles", nbusy, 2 * nbytes);
        check("R10 busy low with done", {31'h0, busy}, 0);
        @(negedge clk);
        check("R10 done one cycle", {31'h0, done}, 0);
        mon_on = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12 busy in reset", {31'h0, busy}, 0);
        check("R12 strobes in reset", {30'h0, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 idle after reset", {29'h0, busy, done, mem_rd | mem_wr}, 0);

        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i].mode, VEC[i].src, VEC[i].dst, VEC[i].len, VEC[i].last,
                $sformatf("R%0d vec%0d", (VEC[i].mode > 3'd4) ? 6 : int'(VEC[i].mode) + 1, i),
                1'b0);
        end

        // R11: start during a transfer is ignored
        run(3'd0, 16'h7100, 16'h7200, 16'd4, 16'h7203, "R11 poke", 1'b1);
        mon_on = 1'b1;
        nwr = 0;
        repeat (4) @(negedge clk);
        check("R11 quiet after ignored start", nwr, 0);
        mon_on = 1'b0;

        // R8: count zero means 65536 bytes (destination held, R3)
        run(3'd2, 16'h0000, 16'h7000, 16'd0, 16'h7000, "R8 R3 full length", 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule